// File: doc/BRIEF.md
# Branch Next-Address and Count-Register Unit

This block works out where instruction fetch goes next after one instruction. It takes a 32-bit instruction word, the address of that instruction, the 32-bit condition register, the count register and the link register. It then produces the next fetch address, a taken flag, and the write enables and new values for the count and link registers.

Three branch forms are recognised:

- A direct branch with a 24-bit displacement that is always taken.
- A conditional branch with a 14-bit displacement.
- A conditional return through the link register.

A conditional branch is governed by a 5-bit control field. That field can optionally decrement the count register and test the result for zero or non-zero. It can also test one selectable condition-register bit for true or false. Any other instruction simply advances the address by four.

All results are registered. The outputs show the inputs sampled at the previous rising clock edge. A surrounding pipeline presents one instruction per cycle and picks up the results one cycle later. Bit numbering in this document is little-endian (bit 31 is the MSB of the instruction word).

Top module: `bru_next_addr`

## Requirements
- R1: A clock edge with `rst_n` low clears `nia_o`, `taken_o`, `ctr_we_o`, `ctr_val_o`, `lr_we_o` and `lr_val_o` to zero.
- R2: Every output reflects the inputs sampled at the preceding rising edge (one cycle of latency).
- R3: Opcode `instr[31:26]`=18 is always taken. Its displacement is `instr[25:2]` with two zero bits appended and sign-extended to 32 bits. When `instr[1]`=1 that displacement is the target; when `instr[1]`=0 it is added to `cia_i`.
- R4: Opcode 16 uses `instr[15:2]` with two zero bits appended and sign-extended as its displacement, with the same `instr[1]` absolute/relative rule. It is taken as R6 and R7 decide.
- R5: Opcode 19 with `instr[10:1]`=16 targets `{lr_i[31:2],2'b00}`, using the incoming link value even when it also writes the link register. It is taken as R6 and R7 decide.
- R6: For the R4 and R5 forms, `instr[23]`=0 asserts `ctr_we_o` with `ctr_val_o` = `ctr_i`−1 mod 2^32. The count test passes when `instr[23]`=1, or when (`ctr_i`−1 ≠ 0) XOR `instr[22]`.
- R7: The condition test passes when `instr[25]`=1, or when `cr_i[31−BI]` equals `instr[24]`, where BI=`instr[20:16]` and BI=0 names `cr_i[31]`. The branch is taken only when both the count test and the condition test pass.
- R8: The hint bit `instr[21]` never changes any output. With `instr[25]`=`instr[23]`=1 the R4 and R5 forms are always taken, never write the count register, and ignore `instr[24]` and `instr[22]`.
- R9: Any of the three branch forms with `instr[0]`=1 asserts `lr_we_o` with `lr_val_o` = `cia_i`+4, whether the branch is taken or not.
- R10: When nothing is taken, `nia_o` = `cia_i`+4 mod 2^32. Any other opcode, or opcode 19 with `instr[10:1]`≠16, gives `taken_o`, `ctr_we_o` and `lr_we_o` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| cia_i | input | 32 | Address of that instruction |
| cr_i | input | 32 | Condition register, bit 31 holds condition bit 0 |
| ctr_i | input | 32 | Current count register |
| lr_i | input | 32 | Current link register |
| nia_o | output | 32 | Next instruction address |
| taken_o | output | 1 | Branch redirected fetch |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_val_o | output | 32 | New count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_val_o | output | 32 | New link value |

## Verification
The assertions check the following on every cycle:

- the cleared state after reset;
- that a not-taken result always lands on the sequential address;
- that the count write value is the decremented input and is only enabled with the decrement bit clear;
- that the link value is the return address and is only written when requested;
- that the direct branch is always taken;
- that unrelated opcodes stay quiet.

Target arithmetic, condition-bit selection, the zero test after the decrement, the ignored hint bit, and the use of the old link value on a linking return can only be shown by the bench. It compares randomized and directed instructions against its own model.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, opcode values and the decoded-instruction record
// for the branch next-address unit. Assumes a 32-bit instruction word with
// the primary opcode in its six most significant bits.
package bru_pkg;
    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int CTL_W     = 5;
    localparam int SEL_W     = 5;
    localparam int XO_W      = 10;
    localparam int LONG_W    = 24;
    localparam int SHORT_W   = 14;

    localparam logic [OPC_W-1:0] OPC_DIRECT = 6'd18;
    localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
    localparam logic [OPC_W-1:0] OPC_GROUP  = 6'd19;
    localparam logic [XO_W-1:0]  XO_TO_LINK = 10'd16;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_DIRECT = 2'd1,
        BK_COND   = 2'd2,
        BK_TOLINK = 2'd3
    } br_kind_e;

    // Decoded branch fields; ctl is kept in little-endian order so that
    // ctl[4] is the leftmost control bit of the instruction.
    typedef struct packed {
        br_kind_e          kind;
        logic [CTL_W-1:0]  ctl;
        logic [SEL_W-1:0]  sel;
        logic              absolute;
        logic              link;
    } br_dec_t;
endpackage

// File: rtl/bru_decode.sv
`timescale 1ns/1ps
// Module: bru_decode
// Classifies the instruction into one of the branch forms and extracts the
// control, selector, absolute and link fields plus the sign-extended byte
// displacement. Assumes ADDR_W is at least 26 so both displacements fit.
module bru_decode
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output br_dec_t            dec,
    output logic [ADDR_W-1:0]  disp
);
    localparam int LONG_EXT  = ADDR_W - LONG_W - 2;
    localparam int SHORT_EXT = ADDR_W - SHORT_W - 2;

    logic [OPC_W-1:0]   opc;
    logic [XO_W-1:0]    xo;
    logic [LONG_W-1:0]  long_fld;
    logic [SHORT_W-1:0] short_fld;

    // Split the instruction into its raw fields.
    always_comb begin
        opc       = instr[INSTR_W-1 -: OPC_W];
        xo        = instr[XO_W:1];
        long_fld  = instr[LONG_W+1:2];
        short_fld = instr[SHORT_W+1:2];
    end

    // Pick the branch form and copy the shared control fields.
    always_comb begin
        dec.kind     = BK_NONE;
        if (opc == OPC_DIRECT)
            dec.kind = BK_DIRECT;
        else if (opc == OPC_COND)
            dec.kind = BK_COND;
        else if (opc == OPC_GROUP && xo == XO_TO_LINK)
            dec.kind = BK_TOLINK;
        dec.ctl      = instr[25:21];
        dec.sel      = instr[20:16];
        dec.absolute = instr[1];
        dec.link     = instr[0];
    end

    // Sign-extend the displacement that belongs to the decoded form.
    always_comb begin
        if (dec.kind == BK_DIRECT)
            disp = {{LONG_EXT{long_fld[LONG_W-1]}}, long_fld, 2'b00};
        else
            disp = {{SHORT_EXT{short_fld[SHORT_W-1]}}, short_fld, 2'b00};
    end
endmodule

// File: rtl/bru_cond.sv
`timescale 1ns/1ps
// Module: bru_cond
// Evaluates the count-register and condition-register tests of a
// conditional branch and decides whether it is taken. The single
// decrementer result feeds both the zero test and the write-back value.
// Assumes cr bit 31 holds condition bit 0.
module bru_cond
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CR_W   = 32
) (
    input  logic [CTL_W-1:0]  ctl,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CR_W-1:0]   cr,
    input  logic [ADDR_W-1:0] ctr,
    output logic [ADDR_W-1:0] ctr_dec,
    output logic              dec_req,
    output logic              pass
);
    localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(CR_W - 1);

    logic             skip_ctr;
    logic             want_zero;
    logic             skip_cr;
    logic             want_bit;
    logic [SEL_W-1:0] cr_idx;
    logic             ctr_ok;
    logic             cr_ok;

    // Name the control bits by their role.
    always_comb begin
        skip_cr   = ctl[4];
        want_bit  = ctl[3];
        skip_ctr  = ctl[2];
        want_zero = ctl[1];
    end

    // Decrement the count and apply the zero or non-zero test.
    always_comb begin
        ctr_dec = ctr - ADDR_W'(1);
        dec_req = ~skip_ctr;
        ctr_ok  = skip_ctr | ((ctr_dec != '0) ^ want_zero);
    end

    // Select the condition bit and compare it with the wanted sense.
    always_comb begin
        cr_idx = TOP_IDX - sel;
        cr_ok  = skip_cr | (cr[cr_idx] == want_bit);
        pass   = ctr_ok & cr_ok;
    end
endmodule

// File: rtl/bru_target.sv
`timescale 1ns/1ps
// Module: bru_target
// Forms the sequential address, the branch target for each form and the
// resulting next address. Assumes addresses wrap modulo 2^ADDR_W.
module bru_target
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  br_kind_e          kind,
    input  logic              absolute,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] cia,
    input  logic [ADDR_W-1:0] lr,
    input  logic              take,
    output logic [ADDR_W-1:0] seq,
    output logic [ADDR_W-1:0] nia
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] tgt;

    // Compute the fall-through and the displacement-based target.
    always_comb begin
        seq     = cia + STEP;
        rel_tgt = absolute ? disp : (cia + disp);
    end

    // Choose the target of the form, then the address that fetch follows.
    always_comb begin
        if (kind == BK_TOLINK)
            tgt = {lr[ADDR_W-1:2], 2'b00};
        else
            tgt = rel_tgt;
        nia = take ? tgt : seq;
    end
endmodule

// File: rtl/bru_next_addr.sv
`timescale 1ns/1ps
// Module: bru_next_addr (top)
// Branch next-address and count-register unit. Decodes one instruction per
// cycle, evaluates its branch condition and registers the next address,
// taken flag and count/link write-backs. One cycle of latency; the link
// target uses the incoming link value before any link write.
module bru_next_addr
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CR_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [ADDR_W-1:0]   cia_i,
    input  logic [CR_W-1:0]     cr_i,
    input  logic [ADDR_W-1:0]   ctr_i,
    input  logic [ADDR_W-1:0]   lr_i,
    output logic [ADDR_W-1:0]   nia_o,
    output logic                taken_o,
    output logic                ctr_we_o,
    output logic [ADDR_W-1:0]   ctr_val_o,
    output logic                lr_we_o,
    output logic [ADDR_W-1:0]   lr_val_o
);
    br_dec_t           dec;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] ctr_dec;
    logic              dec_req;
    logic              cond_pass;
    logic              is_cond_form;
    logic              is_branch;
    logic              take;
    logic [ADDR_W-1:0] seq;
    logic [ADDR_W-1:0] nia_d;
    logic              live_q;

    bru_decode #(.ADDR_W(ADDR_W)) u_decode (
        .instr (instr_i),
        .dec   (dec),
        .disp  (disp)
    );

    bru_cond #(.ADDR_W(ADDR_W), .CR_W(CR_W)) u_cond (
        .ctl     (dec.ctl),
        .sel     (dec.sel),
        .cr      (cr_i),
        .ctr     (ctr_i),
        .ctr_dec (ctr_dec),
        .dec_req (dec_req),
        .pass    (cond_pass)
    );

    // Combine the form with the condition outcome.
    always_comb begin
        is_cond_form = (dec.kind == BK_COND) || (dec.kind == BK_TOLINK);
        is_branch    = (dec.kind != BK_NONE);
        take         = (dec.kind == BK_DIRECT) || (is_cond_form && cond_pass);
    end

    bru_target #(.ADDR_W(ADDR_W)) u_target (
        .kind     (dec.kind),
        .absolute (dec.absolute),
        .disp     (disp),
        .cia      (cia_i),
        .lr       (lr_i),
        .take     (take),
        .seq      (seq),
        .nia      (nia_d)
    );

    // Register all results; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nia_o     <= '0;
            taken_o   <= 1'b0;
            ctr_we_o  <= 1'b0;
            ctr_val_o <= '0;
            lr_we_o   <= 1'b0;
            lr_val_o  <= '0;
        end else begin
            nia_o     <= nia_d;
            taken_o   <= take;
            ctr_we_o  <= is_cond_form && dec_req;
            ctr_val_o <= ctr_dec;
            lr_we_o   <= is_branch && dec.link;
            lr_val_o  <= seq;
        end
    end

    // Mark that outputs hold a computed result rather than reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (nia_o == '0 && !taken_o && !ctr_we_o && !lr_we_o
                     && ctr_val_o == '0 && lr_val_o == '0)); // R1
    AST_SEQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !taken_o) |-> (nia_o == $past(cia_i) + ADDR_W'(4))); // R10
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && lr_we_o) |-> (lr_val_o == $past(cia_i) + ADDR_W'(4)
                                 && $past(instr_i[0]))); // R9
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ctr_we_o) |-> (ctr_val_o == $past(ctr_i) - ADDR_W'(1)
                                  && !$past(instr_i[23]))); // R6
    AST_DIRECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(instr_i[31:26]) == OPC_DIRECT) |-> taken_o); // R3
    AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(instr_i[31:26]) != OPC_DIRECT
                && $past(instr_i[31:26]) != OPC_COND
                && $past(instr_i[31:26]) != OPC_GROUP)
        |-> (!taken_o && !ctr_we_o && !lr_we_o)); // R10
endmodule

// File: tb/bru_next_addr_bench.sv
`timescale 1ns/1ps
module bru_next_addr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0, cia_i = '0, cr_i = '0, ctr_i = '0, lr_i = '0;
    logic [31:0] nia_o, ctr_val_o, lr_val_o;
    logic        taken_o, ctr_we_o, lr_we_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bru_next_addr u_bru_next_addr (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cia_i(cia_i),
        .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i), .nia_o(nia_o),
        .taken_o(taken_o), .ctr_we_o(ctr_we_o), .ctr_val_o(ctr_val_o),
        .lr_we_o(lr_we_o), .lr_val_o(lr_val_o)
    );

    typedef struct packed {
        logic [31:0] nia;
        logic        taken;
        logic        cwe;
        logic [31:0] cval;
        logic        lwe;
        logic [31:0] lval;
    } res_t;

    // Reference model written from the requirements (big-endian field view).
    function automatic res_t model(input logic [31:0] ins, cia, cr, ctr, lr);
        res_t r;
        logic [5:0] op = ins[31:26];
        bit f_dir = (op == 6'd18);
        bit f_bc  = (op == 6'd16);
        bit f_lr  = (op == 6'd19) && (ins[10:1] == 10'd16);
        logic [31:0] dec = ctr - 32'd1;
        logic [31:0] off;
        logic [31:0] tgt;
        logic signed [25:0] l26 = {ins[25:2], 2'b00};
        logic signed [15:0] s16 = {ins[15:2], 2'b00};
        bit b0 = ins[25], b1 = ins[24], b2 = ins[23], b3 = ins[22];
        int bi = ins[20:16];
        bit ok_c, ok_r;
        r = '0;
        off = f_dir ? 32'(l26) : 32'(s16);
        tgt = ins[1] ? off : cia + off;
        if (f_lr) tgt = {lr[31:2], 2'b00};
        ok_c = b2 || ((dec != 0) ^ b3);
        ok_r = b0 || (cr[31 - bi] == b1);
        r.taken = f_dir || ((f_bc || f_lr) && ok_c && ok_r);
        r.cwe   = (f_bc || f_lr) && !b2;
        r.cval  = dec;
        r.lwe   = (f_dir || f_bc || f_lr) && ins[0];
        r.lval  = cia + 32'd4;
        r.nia   = r.taken ? tgt : cia + 32'd4;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one vector at the falling edge, then compare one cycle later (R2).
    task automatic run(input string req, input logic [31:0] ins, cia, cr, ctr, lr);
        res_t e = model(ins, cia, cr, ctr, lr);
        instr_i = ins; cia_i = cia; cr_i = cr; ctr_i = ctr; lr_i = lr;
        @(negedge clk);
        chk({req, " R2 nia"}, nia_o, e.nia);
        chk({req, " taken"}, {31'd0, taken_o}, {31'd0, e.taken});
        chk("R6 ctr_we", {31'd0, ctr_we_o}, {31'd0, e.cwe});
        if (e.cwe) chk("R6 ctr_val", ctr_val_o, e.cval);
        chk("R9 lr_we", {31'd0, lr_we_o}, {31'd0, e.lwe});
        if (e.lwe) chk("R9 lr_val", lr_val_o, e.lval);
    endtask

    function automatic logic [31:0] mk_bc(input logic [4:0] bo, bi,
                                          input logic [13:0] bd,
                                          input logic aa, lk);
        return {6'd16, bo, bi, bd, aa, lk};
    endfunction

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        instr_i = {6'd18, 24'hFFFFFF, 2'b01};
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        chk("R1 nia", nia_o, 32'd0);
        chk("R1 flags", {29'd0, taken_o, ctr_we_o, lr_we_o}, 32'd0);
        chk("R1 values", ctr_val_o | lr_val_o, 32'd0);
        rst_n = 1'b1;

        // R3: negative relative, absolute, linking direct branch
        run("R3", {6'd18, 24'hFFFFFE, 2'b00}, 32'h0000_1000, 0, 0, 0);
        run("R3", {6'd18, 24'h000100, 2'b10}, 32'h1234_5678, 0, 0, 0);
        run("R3", {6'd18, 24'h800000, 2'b11}, 32'h0000_0040, 0, 0, 0);
        // R4: negative short displacement, condition on cr bit 0
        run("R4 R7", mk_bc(5'b01100, 5'd0, 14'h3FFF, 1'b0, 1'b0), 32'h100, 32'h8000_0000, 5, 0);
        run("R4 R7", mk_bc(5'b01100, 5'd31, 14'h0010, 1'b1, 1'b0), 32'h100, 32'h0000_0000, 5, 0);
        // R6: decrement to zero, wrap from zero
        run("R6", mk_bc(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h200, 0, 32'd1, 0);
        run("R6", mk_bc(5'b10010, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h200, 0, 32'd1, 0);
        run("R6", mk_bc(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h200, 0, 32'd0, 0);
        // R5: linking return uses the old link value
        run("R5 R9", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd16, 1'b1}, 32'h300, 0, 0, 32'hABCD_0123);
        run("R5", {6'd19, 5'b00100, 5'd3, 5'd0, 10'd16, 1'b0}, 32'h300, 32'h0000_0000, 0, 32'h0000_0FF7);
        // R8: hint bit and z bits have no effect
        run("R8", mk_bc(5'b10100, 5'd0, 14'h0020, 1'b0, 1'b0), 32'h400, 0, 32'd1, 0);
        run("R8", mk_bc(5'b11111, 5'd0, 14'h0020, 1'b0, 1'b0), 32'h400, 0, 32'd1, 0);
        run("R8", mk_bc(5'b00001, 5'd7, 14'h0020, 1'b0, 1'b0), 32'h400, 0, 32'd9, 0);
        run("R8", mk_bc(5'b00000, 5'd7, 14'h0020, 1'b0, 1'b0), 32'h400, 0, 32'd9, 0);
        // R9: link written when not taken
        run("R9", mk_bc(5'b01100, 5'd2, 14'h0020, 1'b0, 1'b1), 32'h500, 0, 0, 0);
        // R10: sequential wrap and non-branch group opcode
        run("R10", 32'h7C00_0214, 32'hFFFF_FFFC, 0, 0, 0);
        run("R10", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd528, 1'b1}, 32'h600, 0, 0, 32'h700);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins = $urandom;
            logic [31:0] ctr = ($urandom % 3 == 0) ? ($urandom % 3) : $urandom;
            string tag = "R10";
            case ($urandom % 4)
                0: begin ins[31:26] = 6'd18; tag = "R3"; end
                1: begin ins[31:26] = 6'd16; tag = "R4 R7"; end
                2: begin
                    ins[31:26] = 6'd19;
                    if ($urandom % 4 != 0) begin ins[10:1] = 10'd16; tag = "R5 R7"; end
                end
                default: ;
            endcase
            run(tag, ins, $urandom, $urandom, ctr, $urandom);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule